// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Controller

This block moves a block of words between a peripheral and main memory on behalf of the processor. Software writes four settings through a small register port: the direction, the peripheral's bus address, the first memory address and the number of words. It then sets a start bit. From that point the controller runs the whole block with no further software action, and it raises an interrupt when the last word has been moved.

The controller shares one system bus with the processor. For each word it asks for the bus, waits for the grant, and then runs two bus cycles. The first cycle reads the word from the source into an internal holding register. The second cycle writes that word to the destination. It then gives the bus back before it asks for the next word. The processor therefore loses only a short stretch of bus time per word and never changes context.

Top module: `steal_dma`

## Requirements
- R1: After a synchronous reset, `bus_req`, `bus_valid` and `irq` are low, and every register reads zero.
- R2: The register port uses these offsets: 1 holds the peripheral address, 2 the memory address, 3 the word count and 4 the status. Offset 0 is control, with bit 0 as start and bit 1 as direction. Direction 0 moves data from the peripheral to memory and direction 1 moves it from memory to the peripheral. A read of offset 0 returns the direction in bit 1. `cfg_rdata` shows the register at `cfg_addr` one clock later.
- R3: A start with a non-zero count sets status bit 0 (busy) and raises `bus_req`. No bus cycle begins until `bus_grant` has been seen high.
- R4: Each word takes two bus cycles. The first is a read (`bus_write` low) at the source address. The second is a write at the destination address that carries the data the read returned. Each cycle holds `bus_valid` until `bus_ready` is seen high.
- R5: `bus_req` falls in the clock after the write cycle of a word completes, so each bus tenure carries exactly one word.
- R6: After each word, the memory-address register increases by one and the count register decreases by one. The peripheral address stays fixed.
- R7: When the final word completes, busy clears, and status bit 1 (done) and `irq` are set.
- R8: `irq` follows the done bit. It stays high until software writes 1 to status bit 1, and a write of 0 to that bit leaves it set.
- R9: While busy, a write to the control register or to offsets 1 to 3 is ignored, including a second start.
- R10: A start with a count of zero sets done and `irq` in the next clock. It raises no `bus_req` and runs no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Registered read data |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| bus_valid | output | 1 | Bus cycle active |
| bus_write | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | DATA_W | Write data, taken from the holding register |
| bus_rdata | input | DATA_W | Read data returned by the bus |
| bus_ready | input | 1 | Completes the current bus cycle |
| irq | output | 1 | Block-done interrupt |

## Verification
Most internal faults surface when the transfer ends rather than at once. If the address or count sequencing is wrong, memory fills at the wrong locations, the final register values are off, or `irq` arrives after the wrong number of words. A damaged holding register shows up in the very next write cycle, as destination data that differs from what the read returned. A fault in the bus handshake is visible within a clock or two, as a bus cycle without a grant or as more than one word moved per request.

// File: rtl/steal_dma_pkg.sv
package steal_dma_pkg;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_DEV  = 3'd1;
  localparam logic [2:0] OFS_MEM  = 3'd2;
  localparam logic [2:0] OFS_CNT  = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_RD,
    SQ_WR,
    SQ_GAP
  } seq_state_t;

endpackage

// File: rtl/steal_dma_regs.sv
module steal_dma_regs
  import steal_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              seq_busy_i,
  input  logic              step_i,
  input  logic              fin_i,
  output logic              go_o,
  output logic              dir_o,
  output logic [ADDR_W-1:0] dev_o,
  output logic [ADDR_W-1:0] mem_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_o
);

  logic busy_all;
  logic start_hit;
  logic clr_hit;
  logic done_q;
  logic [DATA_W-1:0] rd_n;

  // A start is in flight from the accepting edge until the sequencer takes it.
  assign busy_all  = seq_busy_i | go_o;
  assign start_hit = cfg_we && (cfg_addr == OFS_CTRL) && cfg_wdata[0] && !busy_all;
  assign clr_hit   = cfg_we && (cfg_addr == OFS_STAT) && cfg_wdata[1];
  assign irq_o     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      go_o   <= 1'b0;
      dir_o  <= 1'b0;
      dev_o  <= '0;
      mem_o  <= '0;
      cnt_o  <= '0;
      done_q <= 1'b0;
    end else begin
      go_o <= start_hit && (cnt_o != '0);
      if (!busy_all && cfg_we) begin
        unique case (cfg_addr)
          OFS_CTRL: dir_o <= cfg_wdata[1];
          OFS_DEV:  dev_o <= cfg_wdata[ADDR_W-1:0];
          OFS_MEM:  mem_o <= cfg_wdata[ADDR_W-1:0];
          OFS_CNT:  cnt_o <= cfg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (step_i) begin
        mem_o <= mem_o + 1'b1;
        cnt_o <= cnt_o - 1'b1;
      end
      if (fin_i || (start_hit && (cnt_o == '0)))
        done_q <= 1'b1;
      else if (clr_hit)
        done_q <= 1'b0;
    end
  end

  always_comb begin
    rd_n = '0;
    unique case (cfg_addr)
      OFS_CTRL: rd_n[1]          = dir_o;
      OFS_DEV:  rd_n[ADDR_W-1:0] = dev_o;
      OFS_MEM:  rd_n[ADDR_W-1:0] = mem_o;
      OFS_CNT:  rd_n[CNT_W-1:0]  = cnt_o;
      OFS_STAT: rd_n[1:0]        = {done_q, busy_all};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_n;
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    irq_o && !clr_hit |=> irq_o);  // R8

  AST_PARAMS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy_all |=> $stable(dev_o) && $stable(dir_o));  // R9

  AST_ZERO_START: assert property (@(posedge clk) disable iff (rst)
    start_hit && (cnt_o == '0) |=> !go_o && irq_o);  // R10

endmodule

// File: rtl/steal_dma_seq.sv
module steal_dma_seq
  import steal_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] dev_i,
  input  logic [ADDR_W-1:0] mem_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              bus_grant_i,
  input  logic              bus_ready_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_req_o,
  output logic              bus_valid_o,
  output logic              bus_write_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              busy_o,
  output logic              step_o,
  output logic              fin_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  seq_state_t st_q;

  assign busy_o = (st_q != SQ_IDLE);
  assign step_o = (st_q == SQ_WR) && bus_ready_i;
  assign fin_o  = step_o && (cnt_i == CNT_LAST);

  // bus_wdata_o doubles as the one-word holding register.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= SQ_IDLE;
      bus_req_o   <= 1'b0;
      bus_valid_o <= 1'b0;
      bus_write_o <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (go_i) begin
          st_q      <= SQ_REQ;
          bus_req_o <= 1'b1;
        end
        SQ_REQ: if (bus_grant_i) begin
          st_q        <= SQ_RD;
          bus_valid_o <= 1'b1;
          bus_write_o <= 1'b0;
          bus_addr_o  <= dir_i ? mem_i : dev_i;
        end
        SQ_RD: if (bus_ready_i) begin
          st_q        <= SQ_WR;
          bus_write_o <= 1'b1;
          bus_addr_o  <= dir_i ? dev_i : mem_i;
          bus_wdata_o <= bus_rdata_i;
        end
        SQ_WR: if (bus_ready_i) begin
          st_q        <= (cnt_i == CNT_LAST) ? SQ_IDLE : SQ_GAP;
          bus_valid_o <= 1'b0;
          bus_write_o <= 1'b0;
          bus_req_o   <= 1'b0;
        end
        SQ_GAP: begin
          st_q      <= SQ_REQ;
          bus_req_o <= 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    bus_valid_o |-> bus_req_o);  // R3

  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid_o) |-> $past(bus_grant_i));  // R3

  AST_READ_LEADS: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid_o) |-> !bus_write_o);  // R4

  AST_HOLD_CARRIED: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_write_o) |-> bus_wdata_o == $past(bus_rdata_i));  // R4

  AST_ONE_WORD_TENURE: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req_o) |-> $past(bus_valid_o && bus_write_o && bus_ready_i));  // R5

endmodule

// File: rtl/steal_dma.sv
module steal_dma #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic              irq
);

  logic              go;
  logic              dir;
  logic [ADDR_W-1:0] dev_a;
  logic [ADDR_W-1:0] mem_a;
  logic [CNT_W-1:0]  cnt;
  logic              seq_busy;
  logic              step;
  logic              fin;

  steal_dma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .seq_busy_i(seq_busy), .step_i(step), .fin_i(fin),
    .go_o(go), .dir_o(dir), .dev_o(dev_a), .mem_o(mem_a), .cnt_o(cnt),
    .irq_o(irq)
  );

  steal_dma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst(rst),
    .go_i(go), .dir_i(dir), .dev_i(dev_a), .mem_i(mem_a), .cnt_i(cnt),
    .bus_grant_i(bus_grant), .bus_ready_i(bus_ready), .bus_rdata_i(bus_rdata),
    .bus_req_o(bus_req), .bus_valid_o(bus_valid), .bus_write_o(bus_write),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .busy_o(seq_busy), .step_o(step), .fin_o(fin)
  );

endmodule

// File: tb/steal_dma_tb_top.sv
module steal_dma_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 12;
  localparam int LAT = 1;
  localparam logic [AW-1:0] DEV_PORT = 16'h0030;
  localparam logic [2:0] A_CTRL = 3'd0, A_DEV = 3'd1, A_MEM = 3'd2, A_CNT = 3'd3, A_STAT = 3'd4;

  logic clk, rst, cfg_we;
  logic [2:0] cfg_addr;
  logic [DW-1:0] cfg_wdata, cfg_rdata, bus_wdata, bus_rdata;
  logic bus_req, bus_grant, bus_valid, bus_write, bus_ready, irq;
  logic [AW-1:0] bus_addr;

  int n_vec = 0;
  int n_bad = 0;
  int gdly = 2;
  logic [DW-1:0] mem_m [0:63];
  logic [DW-1:0] dev_log [0:15];
  int stream_idx, dev_log_n, cyc_n, ten_n, viol_n;

  steal_dma #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_req(bus_req), .bus_grant(bus_grant), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // Bus slave: peripheral streams values at DEV_PORT, memory elsewhere.
  initial begin
    int wcnt;
    for (int i = 0; i < 64; i++) mem_m[i] = 32'hC0DE_0000 + i;
    stream_idx = 0; dev_log_n = 0; cyc_n = 0; viol_n = 0;
    bus_ready = 1'b0; bus_rdata = '0; wcnt = 0;
    forever begin
      @(negedge clk);
      if (bus_valid && !bus_grant) viol_n++;
      if (bus_ready) begin
        bus_ready = 1'b0;
        wcnt = 0;
      end else if (bus_valid) begin
        if (wcnt == LAT) begin
          if (bus_write) begin
            if (bus_addr == DEV_PORT) begin
              dev_log[dev_log_n % 16] = bus_wdata;
              dev_log_n++;
            end else mem_m[bus_addr[5:0]] = bus_wdata;
          end else begin
            if (bus_addr == DEV_PORT) begin
              bus_rdata = 32'hA500_0000 + stream_idx;
              stream_idx++;
            end else bus_rdata = mem_m[bus_addr[5:0]];
          end
          bus_ready = 1'b1;
          cyc_n++;
        end else wcnt++;
      end
    end
  end

  // Arbiter with programmable grant delay; counts bus tenures.
  initial begin
    int gcnt;
    logic prev_req;
    bus_grant = 1'b0; gcnt = 0; prev_req = 1'b0; ten_n = 0;
    forever begin
      @(negedge clk);
      if (bus_req && !prev_req) ten_n++;
      prev_req = bus_req;
      if (!bus_req) begin
        bus_grant = 1'b0;
        gcnt = 0;
      end else if (!bus_grant) begin
        if (gcnt >= gdly) bus_grant = 1'b1;
        else gcnt++;
      end
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic wait_done(input string req);
    int k;
    for (k = 0; k < 500 && !irq; k++) @(negedge clk);
    check(req, {31'd0, irq}, 32'd1);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    check("R1 bus_req", {31'd0, bus_req}, 32'd0);
    check("R1 bus_valid", {31'd0, bus_valid}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(A_STAT, v); check("R1 status", v, 32'd0);
    rd(A_MEM, v);  check("R1 mem reg", v, 32'd0);
  endtask

  task automatic t_program;
    logic [DW-1:0] v;
    wr(A_DEV, 32'h0030); wr(A_MEM, 32'h0008); wr(A_CNT, 32'd4);
    rd(A_DEV, v); check("R2 dev reg", v, 32'h30);
    rd(A_MEM, v); check("R2 mem reg", v, 32'h08);
    rd(A_CNT, v); check("R2 cnt reg", v, 32'd4);
    wr(A_CTRL, 32'd2);
    rd(A_CTRL, v); check("R2 dir readback", v, 32'd2);
    wr(A_CTRL, 32'd0);
    rd(A_CTRL, v); check("R2 dir cleared", v, 32'd0);
  endtask

  task automatic t_dev_to_mem;
    logic [DW-1:0] v;
    int s0, c0, t0;
    gdly = 3; s0 = stream_idx; c0 = cyc_n; t0 = ten_n;
    wr(A_CTRL, 32'd1);
    rd(A_STAT, v); check("R3 busy after start", v, 32'd1);
    check("R3 req raised", {31'd0, bus_req}, 32'd1);
    check("R3 no cycle before grant", {31'd0, bus_valid}, 32'd0);
    wait_done("R7 irq after block");
    for (int k = 0; k < 4; k++)
      check("R4 memory word", mem_m[8+k], 32'hA500_0000 + s0 + k);
    check("R4 two cycles per word", cyc_n - c0, 32'd8);
    check("R5 one tenure per word", ten_n - t0, 32'd4);
    check("R3 no ungranted cycle", viol_n, 32'd0);
    rd(A_MEM, v); check("R6 mem advanced", v, 32'h0C);
    rd(A_CNT, v); check("R6 count zero", v, 32'd0);
    rd(A_DEV, v); check("R6 dev fixed", v, 32'h30);
    rd(A_STAT, v); check("R7 status done", v, 32'd2);
  endtask

  task automatic t_irq_clear;
    logic [DW-1:0] v;
    wr(A_STAT, 32'd0);
    check("R8 write 0 keeps irq", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'd2);
    check("R8 write 1 clears irq", {31'd0, irq}, 32'd0);
    rd(A_STAT, v); check("R8 status cleared", v, 32'd0);
  endtask

  task automatic t_mem_to_dev;
    logic [DW-1:0] v;
    int l0;
    gdly = 0; l0 = dev_log_n;
    wr(A_MEM, 32'h20); wr(A_CNT, 32'd3);
    wr(A_CTRL, 32'd3);
    wait_done("R7 irq mem to dev");
    check("R4 dev writes", dev_log_n - l0, 32'd3);
    for (int k = 0; k < 3; k++)
      check("R4 dev word", dev_log[(l0+k) % 16], 32'hC0DE_0020 + k);
    rd(A_MEM, v); check("R6 mem advanced dir1", v, 32'h23);
    wr(A_STAT, 32'd2);
  endtask

  task automatic t_busy_ignore;
    logic [DW-1:0] v;
    int s0, c0;
    gdly = 4; s0 = stream_idx; c0 = cyc_n;
    wr(A_MEM, 32'h10); wr(A_CNT, 32'd5);
    wr(A_CTRL, 32'd1);
    wr(A_CTRL, 32'd3);
    wr(A_CNT, 32'd9);
    wr(A_MEM, 32'h3F);
    wr(A_DEV, 32'h11);
    wait_done("R9 irq after guarded block");
    check("R9 cycle count kept", cyc_n - c0, 32'd10);
    rd(A_MEM, v); check("R9 mem unaffected", v, 32'h15);
    rd(A_DEV, v); check("R9 dev unaffected", v, 32'h30);
    rd(A_CTRL, v); check("R9 dir unaffected", v, 32'd0);
    check("R9 last word placed", mem_m[6'h14], 32'hA500_0000 + s0 + 4);
    wr(A_STAT, 32'd2);
  endtask

  task automatic t_zero_count;
    logic [DW-1:0] v;
    int t0, c0;
    t0 = ten_n; c0 = cyc_n;
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'd1);
    check("R10 irq at once", {31'd0, irq}, 32'd1);
    rd(A_STAT, v); check("R10 done not busy", v, 32'd2);
    repeat (5) @(negedge clk);
    check("R10 no request", ten_n - t0, 32'd0);
    check("R10 no bus cycle", cyc_n - c0, 32'd0);
    wr(A_STAT, 32'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_dev_to_mem();
    t_irq_clear();
    t_mem_to_dev();
    t_busy_ignore();
    t_zero_count();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule